// File: doc/BRIEF.md
# Load/Store Effective Privilege Resolver

This block works out the privilege, the guest state and the translation regime that apply to data loads and stores. A hart that supports a guest layer has two controls that let a privileged program make its memory accesses as if it ran in another mode. The machine-level control takes its target from the machine previous-mode fields. The supervisor-level control takes its target from the supervisor previous-privilege bit and the supervisor previous-guest bit. The resolver applies both controls, resolves their priority and reports the mode the memory pipeline must use.

It also chooses the status bits that apply to the access. The bits are the permit-user-page bit (SUM) and the make-executable-readable bit (MXR), and each comes in a foreground copy and a background copy. The resolver picks each bit from the copy that belongs to the translation level it governs. The block is purely combinational, so all outputs follow the inputs in the same cycle. Instruction fetch, the page-table walk and the permission checks are handled elsewhere.

Privilege codes used on every port: 0 = user, 1 = supervisor, 3 = machine.

Top module: `lsu_priv_resolver`

## Requirements
- R1: When the current privilege is not machine and the supervisor modify control is clear, effPriv equals curPriv and effVirt equals curVirt.
- R2: When the current privilege is not machine and sprvEn=1, effPriv is {0,sppBit} and effVirt is spvBit. The four cases are: spvBit=0 with sppBit=0 gives user; spvBit=0 with sppBit=1 gives supervisor; spvBit=1 with sppBit=0 gives guest user; spvBit=1 with sppBit=1 gives guest supervisor.
- R3: The supervisor modify control takes effect in user, guest-supervisor and guest-user modes as well as in host supervisor mode.
- R4: In machine mode with mprvEn=0, sprvEn has no effect. The result is effPriv=3, effVirt=0 and noXlate=1.
- R5: In machine mode with mprvEn=1, mppField not 3 and sprvEn=0, effPriv equals mppField and effVirt equals mpvField.
- R6: In machine mode with mprvEn=1 and mppField=3, the access is machine level (effPriv=3, effVirt=0, noXlate=1) whatever sprvEn holds.
- R7: In machine mode with mprvEn=1, mppField not 3 and sprvEn=1, sppBit replaces mppField and spvBit replaces mpvField.
- R8: noXlate is 1 exactly when effPriv=3. twoLevel equals effVirt, and effVirt is 0 whenever noXlate is 1.
- R9: hostPriv, the privilege seen by host-level protection, is user (0) whenever effVirt=1 and equals effPriv otherwise.
- R10: The host copy of the status bits is the foreground copy when curVirt=0 and the background copy when curVirt=1. The other copy is the guest copy. sumSel takes the guest copy for two-level accesses, the host copy for single-level accesses, and is 0 when noXlate=1.
- R11: For two-level accesses, guestMxr is the OR of both MXR copies and hostMxr is the host copy. For single-level accesses, guestMxr is 0 and hostMxr is the host copy. When noXlate=1, both are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| curPriv | input | 2 | Current privilege code (0, 1 or 3) |
| curVirt | input | 1 | Current guest state |
| mprvEn | input | 1 | Machine-level modify control |
| mppField | input | 2 | Machine previous privilege |
| mpvField | input | 1 | Machine previous guest state |
| sprvEn | input | 1 | Supervisor-level modify control |
| sppBit | input | 1 | Supervisor previous privilege (0 user, 1 supervisor) |
| spvBit | input | 1 | Supervisor previous guest state |
| fgSum | input | 1 | Foreground permit-user-page bit |
| bgSum | input | 1 | Background permit-user-page bit |
| fgMxr | input | 1 | Foreground make-executable-readable bit |
| bgMxr | input | 1 | Background make-executable-readable bit |
| effPriv | output | 2 | Privilege used for the access |
| effVirt | output | 1 | Guest state used for the access |
| noXlate | output | 1 | Access bypasses translation |
| twoLevel | output | 1 | Guest and host translation both apply |
| hostPriv | output | 2 | Privilege applied by host-level protection |
| sumSel | output | 1 | Selected permit-user-page bit |
| guestMxr | output | 1 | MXR applied at the guest translation level |
| hostMxr | output | 1 | MXR applied at the host translation level |

## Verification
The assertions assume the inputs describe a legal hart state. curPriv and mppField are never the reserved code 2, and curVirt is never 1 while curPriv is machine. No check covers the outputs for illegal states. The random stimulus draws both privilege fields only from the three legal codes and forces curVirt low whenever machine mode is chosen. Directed cases then cover each modify-control path, the machine previous-mode value of 3 together with the supervisor control, and both settings of curVirt for the status-copy selection.

// File: rtl/lspr_pkg.sv
package lspr_pkg;
  localparam int PRIV_W = 2;
  typedef logic [PRIV_W-1:0] priv_t;
  localparam priv_t PRIV_U = priv_t'(0);
  localparam priv_t PRIV_S = priv_t'(1);
  localparam priv_t PRIV_M = priv_t'(3);

  // one strobe per source of the effective mode; none set = current mode
  typedef struct packed {
    logic forceMach;
    logic useMachPrev;
    logic useSupPrev;
  } selStrobes_t;
endpackage

// File: rtl/lspr_ctrl.sv
module lspr_ctrl
  import lspr_pkg::*;
(
  input  priv_t       curPriv,
  input  logic        mprvEn,
  input  priv_t       mppField,
  input  logic        sprvEn,
  output selStrobes_t strobes
);
  logic inMach;

  always_comb begin
    inMach  = (curPriv == PRIV_M);
    strobes = '0;
    if (inMach) begin
      if (!mprvEn || (mppField == PRIV_M)) strobes.forceMach = 1'b1;
      else if (sprvEn)                     strobes.useSupPrev = 1'b1;
      else                                 strobes.useMachPrev = 1'b1;
    end else if (sprvEn) begin
      strobes.useSupPrev = 1'b1;
    end
  end

  always_comb begin
    if (!inMach && mprvEn && !sprvEn)
      AST_MPRV_OUTSIDE_MACH: assert (strobes == '0) else $error("mprv outside machine"); // R1
  end
endmodule

// File: rtl/lspr_path.sv
module lspr_path
  import lspr_pkg::*;
(
  input  selStrobes_t strobes,
  input  priv_t       curPriv,
  input  logic        curVirt,
  input  priv_t       mppField,
  input  logic        mpvField,
  input  logic        sppBit,
  input  logic        spvBit,
  input  logic        fgSum,
  input  logic        bgSum,
  input  logic        fgMxr,
  input  logic        bgMxr,
  output priv_t       effPriv,
  output logic        effVirt,
  output logic        noXlate,
  output logic        twoLevel,
  output priv_t       hostPriv,
  output logic        sumSel,
  output logic        guestMxr,
  output logic        hostMxr
);
  priv_t selPriv;
  logic  selVirt;
  logic  hostSum, guestSum, hostMxrCopy, guestMxrCopy;

  // mode source multiplexer
  always_comb begin
    if (strobes.forceMach) begin
      selPriv = PRIV_M;
      selVirt = 1'b0;
    end else if (strobes.useSupPrev) begin
      selPriv = {{(PRIV_W-1){1'b0}}, sppBit};
      selVirt = spvBit;
    end else if (strobes.useMachPrev) begin
      selPriv = mppField;
      selVirt = mpvField;
    end else begin
      selPriv = curPriv;
      selVirt = curVirt;
    end
  end

  // status copy selection: host copy is foreground unless currently a guest
  always_comb begin
    hostSum      = curVirt ? bgSum : fgSum;
    guestSum     = curVirt ? fgSum : bgSum;
    hostMxrCopy  = curVirt ? bgMxr : fgMxr;
    guestMxrCopy = curVirt ? fgMxr : bgMxr;
  end

  always_comb begin
    noXlate  = (selPriv == PRIV_M);
    twoLevel = selVirt & ~noXlate;
    effPriv  = selPriv;
    effVirt  = twoLevel;
    hostPriv = twoLevel ? PRIV_U : selPriv;
    if (noXlate)       sumSel = 1'b0;
    else if (twoLevel) sumSel = guestSum;
    else               sumSel = hostSum;
    hostMxr  = noXlate ? 1'b0 : hostMxrCopy;
    guestMxr = twoLevel ? (guestMxrCopy | hostMxrCopy) : 1'b0;
  end

  always_comb begin
    if (strobes.forceMach)
      AST_FORCE_MACH_BYPASS: assert (noXlate && !effVirt && !guestMxr) else $error("machine bypass"); // R6
    if (strobes.useMachPrev && mppField != PRIV_M)
      AST_MACH_PREV_XLATE: assert (!noXlate && effVirt == mpvField) else $error("mach prev"); // R5
    if (noXlate)
      AST_NOXLATE_FLAGS: assert (!sumSel && !hostMxr && !twoLevel) else $error("noxlate flags"); // R11
  end
endmodule

// File: rtl/lsu_priv_resolver.sv
module lsu_priv_resolver
  import lspr_pkg::*;
(
  input  logic [1:0] curPriv,
  input  logic       curVirt,
  input  logic       mprvEn,
  input  logic [1:0] mppField,
  input  logic       mpvField,
  input  logic       sprvEn,
  input  logic       sppBit,
  input  logic       spvBit,
  input  logic       fgSum,
  input  logic       bgSum,
  input  logic       fgMxr,
  input  logic       bgMxr,
  output logic [1:0] effPriv,
  output logic       effVirt,
  output logic       noXlate,
  output logic       twoLevel,
  output logic [1:0] hostPriv,
  output logic       sumSel,
  output logic       guestMxr,
  output logic       hostMxr
);
  selStrobes_t strobes;

  lspr_ctrl u_ctrl (
    .curPriv (curPriv),
    .mprvEn  (mprvEn),
    .mppField(mppField),
    .sprvEn  (sprvEn),
    .strobes (strobes)
  );

  lspr_path u_path (
    .strobes (strobes),
    .curPriv (curPriv),
    .curVirt (curVirt),
    .mppField(mppField),
    .mpvField(mpvField),
    .sppBit  (sppBit),
    .spvBit  (spvBit),
    .fgSum   (fgSum),
    .bgSum   (bgSum),
    .fgMxr   (fgMxr),
    .bgMxr   (bgMxr),
    .effPriv (effPriv),
    .effVirt (effVirt),
    .noXlate (noXlate),
    .twoLevel(twoLevel),
    .hostPriv(hostPriv),
    .sumSel  (sumSel),
    .guestMxr(guestMxr),
    .hostMxr (hostMxr)
  );

  always_comb begin
    if (curPriv != PRIV_M && sprvEn)
      AST_SPRV_TARGET: assert (effPriv == {1'b0, sppBit} && effVirt == spvBit) else $error("sprv target"); // R2
    if (curPriv != PRIV_M && !sprvEn)
      AST_PLAIN_PASS: assert (effPriv == curPriv && effVirt == curVirt) else $error("plain pass"); // R1
    if (effVirt)
      AST_GUEST_HOST_USER: assert (hostPriv == PRIV_U && twoLevel) else $error("host user"); // R9
    if (effPriv == PRIV_M)
      AST_MACH_NO_XLATE: assert (noXlate && !effVirt) else $error("mach xlate"); // R8
  end
endmodule

// File: tb/sim_lsu_priv_resolver.sv
module sim_lsu_priv_resolver;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #2 clk = ~clk;

  logic [1:0] curPriv = 2'd0, mppField = 2'd0;
  logic curVirt = 0, mprvEn = 0, mpvField = 0, sprvEn = 0, sppBit = 0, spvBit = 0;
  logic fgSum = 0, bgSum = 0, fgMxr = 0, bgMxr = 0;
  logic [1:0] effPriv, hostPriv;
  logic effVirt, noXlate, twoLevel, sumSel, guestMxr, hostMxr;

  int nChecks = 0;
  int nFails = 0;
  bit done = 0;

  lsu_priv_resolver u0 (.*);

  function automatic logic [9:0] model(
    logic [1:0] cp, logic cv, logic mp, logic [1:0] mpp, logic mpv,
    logic sp, logic spp, logic spv, logic fs, logic bs, logic fm, logic bm);
    logic [1:0] p; logic v; logic nx, tl, hsum, gsum, hmx, gmx, su, gm, hm;
    logic [1:0] hp;
    if (cp == 2'd3) begin
      if (mp && mpp != 2'd3) begin
        if (sp) begin p = {1'b0, spp}; v = spv; end
        else    begin p = mpp; v = mpv; end
      end else begin p = 2'd3; v = 1'b0; end
    end else if (sp) begin p = {1'b0, spp}; v = spv; end
    else begin p = cp; v = cv; end
    if (p == 2'd3) v = 1'b0;
    nx = (p == 2'd3); tl = v; hp = v ? 2'd0 : p;
    hsum = cv ? bs : fs; gsum = cv ? fs : bs;
    hmx = cv ? bm : fm;  gmx = cv ? fm : bm;
    su = nx ? 1'b0 : (tl ? gsum : hsum);
    gm = tl ? (gmx | hmx) : 1'b0;
    hm = nx ? 1'b0 : hmx;
    return {p, v, nx, tl, hp, su, gm, hm};
  endfunction

  function automatic string pathTag(logic [1:0] cp, logic mp, logic [1:0] mpp, logic sp);
    if (cp == 2'd3) begin
      if (mp && mpp == 2'd3) return "R6";
      if (mp && sp) return "R7";
      if (mp) return "R5";
      return "R4";
    end
    if (sp && cp != 2'd1) return "R3";
    if (sp) return "R2";
    return "R1";
  endfunction

  task automatic cmp(string tag, int act, int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic apply(logic [1:0] cp, logic cv, logic mp, logic [1:0] mpp, logic mpv,
                       logic sp, logic spp, logic spv, logic fs, logic bs, logic fm, logic bm);
    logic [9:0] e;
    @(posedge clk);
    curPriv = cp; curVirt = cv; mprvEn = mp; mppField = mpp; mpvField = mpv;
    sprvEn = sp; sppBit = spp; spvBit = spv; fgSum = fs; bgSum = bs; fgMxr = fm; bgMxr = bm;
    @(negedge clk);
    e = model(cp, cv, mp, mpp, mpv, sp, spp, spv, fs, bs, fm, bm);
    cmp(pathTag(cp, mp, mpp, sp), {effPriv, effVirt}, e[9:7]);
    cmp("R8", {noXlate, twoLevel}, e[6:5]);
    cmp("R9", hostPriv, e[4:3]);
    cmp("R10", sumSel, e[2]);
    cmp("R11", {guestMxr, hostMxr}, e[1:0]);
  endtask

  function automatic logic [1:0] legalPriv(int unsigned r);
    case (r % 3)
      0: return 2'd0;
      1: return 2'd1;
      default: return 2'd3;
    endcase
  endfunction

  initial begin
    #100000;
    if (!done) begin
      nChecks++; nFails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    seed = 32'h5eed_1234;
    void'($urandom(seed));
    repeat (3) @(posedge clk);
    // reset-time state: all inputs zero gives a plain user access (R1)
    @(negedge clk);
    cmp("R1", {effPriv, effVirt, noXlate, hostPriv}, 6'b000000);
    rstN = 1'b1;

    // directed: four supervisor-control encodings from host supervisor (R2)
    apply(2'd1, 0, 0, 2'd0, 0, 1, 0, 0, 1, 0, 1, 0);
    apply(2'd1, 0, 0, 2'd0, 0, 1, 1, 0, 1, 0, 1, 0);
    apply(2'd1, 0, 0, 2'd0, 0, 1, 0, 1, 0, 1, 0, 1);
    apply(2'd1, 0, 0, 2'd0, 0, 1, 1, 1, 0, 1, 1, 0); // R10 background SUM
    // supervisor control from user, guest supervisor, guest user (R3)
    apply(2'd0, 0, 0, 2'd0, 0, 1, 1, 1, 1, 0, 0, 1);
    apply(2'd1, 1, 0, 2'd0, 0, 1, 1, 0, 1, 0, 1, 0);
    apply(2'd0, 1, 0, 2'd0, 0, 1, 1, 1, 1, 0, 0, 1);
    // machine, no machine control: supervisor control ignored (R4)
    apply(2'd3, 0, 0, 2'd1, 1, 1, 1, 1, 1, 1, 1, 1);
    // machine previous mode (R5)
    apply(2'd3, 0, 1, 2'd1, 1, 0, 0, 0, 0, 1, 1, 0);
    apply(2'd3, 0, 1, 2'd0, 0, 0, 1, 1, 1, 0, 1, 1);
    // previous mode machine beats supervisor control (R6)
    apply(2'd3, 0, 1, 2'd3, 0, 1, 1, 1, 1, 1, 1, 1);
    // supervisor fields replace machine fields (R7)
    apply(2'd3, 0, 1, 2'd0, 0, 1, 1, 1, 0, 1, 0, 1);
    // plain guest supervisor, copy selection with curVirt=1 (R10, R11)
    apply(2'd1, 1, 0, 2'd0, 0, 0, 0, 0, 1, 0, 0, 1);

    for (int i = 0; i < 3000; i++) begin
      logic [1:0] cp, mpp;
      logic cv;
      cp  = legalPriv($urandom);
      mpp = legalPriv($urandom);
      cv  = (cp == 2'd3) ? 1'b0 : 1'($urandom);
      apply(cp, cv, 1'($urandom), mpp, 1'($urandom), 1'($urandom), 1'($urandom),
            1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom));
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule